// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the byte-wide register front end of an eight-line interrupt controller. It has a single address bit. The writes it receives carry two kinds of traffic: a setup sequence of up to four words, and run-time command words. Setup words program the vector base and the operating modes. Command words program the mask, read selection, poll and special mask, and issue priority and end-of-interrupt commands. The block keeps the configuration registers and hands them to a separate priority core. Rotation and end-of-interrupt requests go to that core as one-cycle command strobes. The priority arithmetic itself is outside this block.

Reads are combinational. Address 1 returns the mask. Address 0 returns either the request vector or the in-service vector, both supplied by the core, depending on the read selection.

An armed poll turns the next read into a one-shot read of the core's selected request number. That read also emits an acknowledge strobe, which the core uses to drop the request and in-service bits of that line.

The setup sequencer has four named states:
- `ST_RUN` is normal operation.
- `ST_BASE` waits for the base word.
- `ST_LINK` waits for the cascade word, which is accepted and ignored.
- `ST_MODE` waits for the optional mode word.

It has these transitions:
- A setup start (address 0, bit 4 set) moves any state to `ST_BASE`.
- An address-1 write moves `ST_BASE` to `ST_LINK`.
- An address-1 write moves `ST_LINK` to `ST_MODE` if a mode word was requested, and to `ST_RUN` otherwise.
- An address-1 write moves `ST_MODE` to `ST_RUN`.

Top module: `pic_prog_port`

## Requirements
- R1: After reset:
  - the sequencer is in `ST_RUN` (`setup_busy` = 0);
  - mask, vector base, auto-EOI, nested mode, rotate-on-auto-EOI, special mask and all strobes are 0;
  - an address-0 read returns `req_vec`.
- R2: An address-0 write with bit 4 set is a setup start, in any state. In the next cycle:
  - `setup_busy` is 1;
  - mask, vector base and special mask are 0;
  - read selection is back to the request vector;
  - `level_clr` pulses for exactly that one cycle;
  - bit 0 of the word is stored as the "mode word follows" flag.
- R3: A setup start with bit 0 = 0 clears `nest_mode` and `auto_eoi`. A setup start with bit 0 = 1 leaves both unchanged.
- R4: In `ST_BASE`, an address-1 write sets `vec_base` to the written byte AND 0xF8 and moves the sequencer to `ST_LINK`.
- R5: In `ST_LINK`, an address-1 write changes no register, including the mask. It moves the sequencer to `ST_MODE` if the mode-word flag is set, and to `ST_RUN` otherwise.
- R6: In `ST_MODE`, an address-1 write sets `nest_mode` from bit 4 and `auto_eoi` from bit 1, and returns the sequencer to `ST_RUN`.
- R7: In `ST_RUN`, an address-1 write loads the mask from the written byte, and an address-1 read returns the mask. The mask changes in no cycle that follows a cycle without a write.
- R8: An address-0 write with bit 4 = 0 and bit 3 = 1 is a view command. If its bit 1 is 1, bit 0 selects what address-0 reads return: 1 gives `svc_vec`, 0 gives `req_vec`. If bit 1 is 0, the selection is kept.
- R9: In a view command, bit 6 = 1 loads `spec_mask` from bit 5. Bit 6 = 0 leaves `spec_mask` unchanged.
- R10: An address-0 write with bits 4 and 3 both 0 is a rank command, with its code in bits 7:5. Code 0 clears `rot_auto_eoi` and code 4 sets it; neither produces a command strobe.
- R11: Rank command codes 1, 3, 5, 6 and 7 produce, in the next cycle only, `cmd_valid` = 1 with `cmd_op` = the code and `cmd_level` = bits 2:0. The codes mean: 1 non-specific EOI, 3 specific EOI, 5 rotating non-specific EOI, 6 set lowest priority, 7 rotating specific EOI. Code 2 produces no strobe and changes no register.
- R12: View command bit 2 arms poll. While poll is armed:
  - the next read returns `pend_num` if `pend_valid` is 1, and returns 7 otherwise;
  - that read disarms poll, so the following read is an ordinary read;
  - if `pend_valid` was 1, `poll_ack` = 1 with `poll_num` = that number in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| req_vec | input | 8 | Request vector from the priority core |
| svc_vec | input | 8 | In-service vector from the priority core |
| pend_valid | input | 1 | Core has a selected pending request |
| pend_num | input | 3 | Line number of the selected request |
| mask_o | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| nest_mode | output | 1 | Nested mode that ignores the cascade line in service |
| rot_auto_eoi | output | 1 | Rotate priority on automatic end-of-interrupt |
| spec_mask | output | 1 | Special mask mode |
| setup_busy | output | 1 | Setup sequence in progress |
| level_clr | output | 1 | One-cycle pulse: core clears its previous-level memory |
| cmd_valid | output | 1 | One-cycle rank command strobe |
| cmd_op | output | 3 | Rank command code |
| cmd_level | output | 3 | Line operand of the rank command |
| poll_ack | output | 1 | One-cycle poll acknowledge |
| poll_num | output | 3 | Line taken by the poll read |

## Verification
A wrong sequencer state shows at the ports one write later. The base byte lands in the mask, or the mask write is swallowed, and an address-1 read or `vec_base` shows it right away. A wrong view or poll flag shows on the very next read, as the wrong vector or a stray poll code. A mis-decoded rank command shows as a missing, extra or mislabelled `cmd_valid` in the cycle after the write.

// File: rtl/pic_port_pkg.sv
package pic_port_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_BASE = 2'd1,
        ST_LINK = 2'd2,
        ST_MODE = 2'd3
    } setup_state_e;

    typedef enum logic [2:0] {
        OP_ROT_OFF    = 3'd0,
        OP_EOI        = 3'd1,
        OP_NOP        = 3'd2,
        OP_EOI_AT     = 3'd3,
        OP_ROT_ON     = 3'd4,
        OP_EOI_ROT    = 3'd5,
        OP_SET_PRIO   = 3'd6,
        OP_EOI_AT_ROT = 3'd7
    } rank_op_e;

    // bit positions inside written bytes
    localparam int SETUP_BIT     = 4;
    localparam int VIEW_BIT      = 3;
    localparam int NEED_MODE_BIT = 0;
    localparam int MODE_NEST_BIT = 4;
    localparam int MODE_AUTO_BIT = 1;
    localparam int POLL_BIT      = 2;
    localparam int SEL_EN_BIT    = 1;
    localparam int SEL_SVC_BIT   = 0;
    localparam int SMASK_EN_BIT  = 6;
    localparam int SMASK_VAL_BIT = 5;
    localparam int OP_W          = 3;

endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode (
    input  logic wr_en,
    input  logic addr,
    input  logic b_setup,
    input  logic b_view,
    output logic setup_start,
    output logic view_wr,
    output logic rank_wr,
    output logic word_wr
);
    always_comb begin
        setup_start = wr_en && !addr && b_setup;
        view_wr     = wr_en && !addr && !b_setup && b_view;
        rank_wr     = wr_en && !addr && !b_setup && !b_view;
        word_wr     = wr_en && addr;
    end
endmodule

// File: rtl/pic_setup_fsm.sv
module pic_setup_fsm
    import pic_port_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         setup_start,
    input  logic         word_wr,
    input  logic         need_mode,
    output setup_state_e state,
    output logic         take_base,
    output logic         take_mode,
    output logic         mask_load
);
    setup_state_e nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_RUN;
        else if (setup_start)
            state <= ST_BASE;
        else
            state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:  nxt = ST_RUN;
            ST_BASE: if (word_wr) nxt = ST_LINK;
            ST_LINK: if (word_wr) nxt = need_mode ? ST_MODE : ST_RUN;
            ST_MODE: if (word_wr) nxt = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        take_base = word_wr && (state == ST_BASE);
        take_mode = word_wr && (state == ST_MODE);
        mask_load = word_wr && (state == ST_RUN);
    end

    // R2
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_start |=> (state == ST_BASE));

    // R5
    link_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LINK && word_wr && !setup_start && !need_mode) |=> (state == ST_RUN));

    // R5
    link_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LINK && word_wr && !setup_start && need_mode) |=> (state == ST_MODE));

endmodule

// File: rtl/pic_view_ctl.sv
module pic_view_ctl #(
    parameter int LINES = 8,
    localparam int DATA_W = LINES,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              setup_start,
    input  logic              view_wr,
    input  logic              poll_req,
    input  logic              sel_en,
    input  logic              sel_svc,
    input  logic              smask_en,
    input  logic              smask_val,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] req_vec,
    input  logic [DATA_W-1:0] svc_vec,
    input  logic [DATA_W-1:0] mask,
    input  logic              pend_valid,
    input  logic [IDX_W-1:0]  pend_num,
    output logic [DATA_W-1:0] rdata,
    output logic              spec_mask,
    output logic              poll_ack,
    output logic [IDX_W-1:0]  poll_num
);
    localparam logic [IDX_W-1:0] IDLE_NUM = IDX_W'(LINES - 1);

    logic poll_armed;
    logic read_svc;
    logic [IDX_W-1:0] poll_code;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_armed <= 1'b0;
            read_svc   <= 1'b0;
            spec_mask  <= 1'b0;
            poll_ack   <= 1'b0;
            poll_num   <= '0;
        end else begin
            poll_ack <= rd_en && poll_armed && pend_valid;
            if (rd_en && poll_armed)
                poll_num <= pend_num;
            if (view_wr && poll_req)
                poll_armed <= 1'b1;
            else if (rd_en)
                poll_armed <= 1'b0;
            if (setup_start) begin
                read_svc  <= 1'b0;
                spec_mask <= 1'b0;
            end else if (view_wr) begin
                if (sel_en)   read_svc  <= sel_svc;
                if (smask_en) spec_mask <= smask_val;
            end
        end
    end

    always_comb begin
        poll_code = pend_valid ? pend_num : IDLE_NUM;
        if (poll_armed)
            rdata = {{(DATA_W-IDX_W){1'b0}}, poll_code};
        else if (addr)
            rdata = mask;
        else
            rdata = read_svc ? svc_vec : req_vec;
    end

    // R12
    poll_ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_ack |-> $past(rd_en && pend_valid));

    // R9
    smask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(view_wr) && !$past(setup_start)) |-> $stable(spec_mask));

endmodule

// File: rtl/pic_prog_port.sv
module pic_prog_port
    import pic_port_pkg::*;
#(
    parameter int LINES = 8,
    localparam int DATA_W = LINES,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] req_vec,
    input  logic [DATA_W-1:0] svc_vec,
    input  logic              pend_valid,
    input  logic [IDX_W-1:0]  pend_num,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] vec_base,
    output logic              auto_eoi,
    output logic              nest_mode,
    output logic              rot_auto_eoi,
    output logic              spec_mask,
    output logic              setup_busy,
    output logic              level_clr,
    output logic              cmd_valid,
    output logic [OP_W-1:0]   cmd_op,
    output logic [IDX_W-1:0]  cmd_level,
    output logic              poll_ack,
    output logic [IDX_W-1:0]  poll_num
);
    localparam logic [DATA_W-1:0] BASE_KEEP = ~DATA_W'(LINES - 1);

    logic setup_start, view_wr, rank_wr, word_wr;
    logic take_base, take_mode, mask_load;
    logic need_mode;
    setup_state_e state;
    rank_op_e op_in;

    assign op_in = rank_op_e'(wdata[DATA_W-1 -: OP_W]);

    pic_cmd_decode u_dec (
        .wr_en       (wr_en),
        .addr        (addr),
        .b_setup     (wdata[SETUP_BIT]),
        .b_view      (wdata[VIEW_BIT]),
        .setup_start (setup_start),
        .view_wr     (view_wr),
        .rank_wr     (rank_wr),
        .word_wr     (word_wr)
    );

    pic_setup_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .setup_start (setup_start),
        .word_wr     (word_wr),
        .need_mode   (need_mode),
        .state       (state),
        .take_base   (take_base),
        .take_mode   (take_mode),
        .mask_load   (mask_load)
    );

    pic_view_ctl #(.LINES(LINES)) u_view (
        .clk         (clk),
        .rst_n       (rst_n),
        .setup_start (setup_start),
        .view_wr     (view_wr),
        .poll_req    (wdata[POLL_BIT]),
        .sel_en      (wdata[SEL_EN_BIT]),
        .sel_svc     (wdata[SEL_SVC_BIT]),
        .smask_en    (wdata[SMASK_EN_BIT]),
        .smask_val   (wdata[SMASK_VAL_BIT]),
        .rd_en       (rd_en),
        .addr        (addr),
        .req_vec     (req_vec),
        .svc_vec     (svc_vec),
        .mask        (mask_o),
        .pend_valid  (pend_valid),
        .pend_num    (pend_num),
        .rdata       (rdata),
        .spec_mask   (spec_mask),
        .poll_ack    (poll_ack),
        .poll_num    (poll_num)
    );

    assign setup_busy = (state != ST_RUN);

    // setup and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o    <= '0;
            vec_base  <= '0;
            need_mode <= 1'b0;
            nest_mode <= 1'b0;
            auto_eoi  <= 1'b0;
            level_clr <= 1'b0;
        end else if (setup_start) begin
            mask_o    <= '0;
            vec_base  <= '0;
            need_mode <= wdata[NEED_MODE_BIT];
            level_clr <= 1'b1;
            if (!wdata[NEED_MODE_BIT]) begin
                nest_mode <= 1'b0;
                auto_eoi  <= 1'b0;
            end
        end else begin
            level_clr <= 1'b0;
            if (take_base) vec_base <= wdata & BASE_KEEP;
            if (take_mode) begin
                nest_mode <= wdata[MODE_NEST_BIT];
                auto_eoi  <= wdata[MODE_AUTO_BIT];
            end
            if (mask_load) mask_o <= wdata;
        end
    end

    // rank commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rot_auto_eoi <= 1'b0;
            cmd_valid    <= 1'b0;
            cmd_op       <= '0;
            cmd_level    <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (rank_wr) begin
                unique case (op_in)
                    OP_ROT_OFF: rot_auto_eoi <= 1'b0;
                    OP_ROT_ON:  rot_auto_eoi <= 1'b1;
                    OP_NOP:     ;
                    OP_EOI, OP_EOI_AT, OP_EOI_ROT, OP_SET_PRIO, OP_EOI_AT_ROT: begin
                        cmd_valid <= 1'b1;
                        cmd_op    <= op_in;
                        cmd_level <= wdata[IDX_W-1:0];
                    end
                endcase
            end
        end
    end

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> (mask_o == $past(mask_o)));

    // R11
    cmd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(wr_en && !addr && wdata[SETUP_BIT:VIEW_BIT] == 2'b00));

    // R2
    busy_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[SETUP_BIT]) |=> (setup_busy && level_clr));

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(auto_eoi) && $stable(nest_mode)));

endmodule

// File: tb/tb_pic_prog_port.sv
`timescale 1ns/1ps
module tb_pic_prog_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] req_vec = '0, svc_vec = '0;
    logic       pend_valid = 1'b0;
    logic [2:0] pend_num = '0;
    logic [7:0] mask_o, vec_base;
    logic       auto_eoi, nest_mode, rot_auto_eoi, spec_mask, setup_busy, level_clr;
    logic       cmd_valid, poll_ack;
    logic [2:0] cmd_op, cmd_level, poll_num;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pic_prog_port dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .req_vec(req_vec), .svc_vec(svc_vec),
        .pend_valid(pend_valid), .pend_num(pend_num), .mask_o(mask_o),
        .vec_base(vec_base), .auto_eoi(auto_eoi), .nest_mode(nest_mode),
        .rot_auto_eoi(rot_auto_eoi), .spec_mask(spec_mask), .setup_busy(setup_busy),
        .level_clr(level_clr), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_level(cmd_level), .poll_ack(poll_ack), .poll_num(poll_num)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    logic [7:0] v;
    logic       exp_rot;
    logic       exp_strobe;

    initial begin
        req_vec = 8'h5A;
        svc_vec = 8'hC3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", setup_busy, 0);
        chk("R1 mask", mask_o, 0);
        chk("R1 base", vec_base, 0);
        chk("R1 flags", {auto_eoi, nest_mode, rot_auto_eoi, spec_mask}, 0);
        chk("R1 strobes", {level_clr, cmd_valid, poll_ack}, 0);
        rd(1'b0, v);
        chk("R1 read0", v, 8'h5A);

        // R7 mask sweep
        for (int m = 0; m < 256; m++) begin
            wr(1'b1, 8'(m));
            rd(1'b1, v);
            chk("R7 mask read", v, m);
        end

        // R2 setup start clears mask, pulses level_clr
        wr(1'b1, 8'hA5);
        wr(1'b0, 8'h10);
        chk("R2 busy", setup_busy, 1);
        chk("R2 level_clr", level_clr, 1);
        chk("R2 mask cleared", mask_o, 0);
        @(negedge clk);
        chk("R2 level_clr one cycle", level_clr, 0);
        wr(1'b1, 8'h33);
        wr(1'b1, 8'h00);

        // R4 / R5 base sweep without mode word
        for (int b = 0; b < 256; b++) begin
            wr(1'b0, 8'h10);
            chk("R2 busy in sweep", setup_busy, 1);
            chk("R2 base cleared", vec_base, 0);
            wr(1'b1, 8'(b));
            chk("R4 base", vec_base, b & 8'hF8);
            chk("R4 still busy", setup_busy, 1);
            wr(1'b1, 8'hFF);
            chk("R5 link done", setup_busy, 0);
            chk("R5 link ignored", mask_o, 0);
        end

        // R6 mode word sweep
        for (int k = 0; k < 4; k++) begin
            logic [7:0] mw;
            mw = {3'b000, k[1], 2'b00, k[0], 1'b0};
            wr(1'b0, 8'h11);
            wr(1'b1, 8'h48);
            wr(1'b1, 8'hEE);
            chk("R5 waits for mode word", setup_busy, 1);
            chk("R5 link ignored", mask_o, 0);
            wr(1'b1, mw);
            chk("R6 nest", nest_mode, k[1]);
            chk("R6 auto", auto_eoi, k[0]);
            chk("R6 done", setup_busy, 0);
            chk("R6 mask untouched", mask_o, 0);
        end

        // R3 retention versus clearing
        wr(1'b0, 8'h11); wr(1'b1, 8'h00); wr(1'b1, 8'h00); wr(1'b1, 8'h12);
        wr(1'b0, 8'h11);
        chk("R3 keep nest", nest_mode, 1);
        chk("R3 keep auto", auto_eoi, 1);
        wr(1'b1, 8'h00); wr(1'b1, 8'h00); wr(1'b1, 8'h12);
        wr(1'b0, 8'h10);
        chk("R3 clear nest", nest_mode, 0);
        chk("R3 clear auto", auto_eoi, 0);
        wr(1'b1, 8'h00); wr(1'b1, 8'h00);

        // R2 restart mid-sequence
        wr(1'b0, 8'h10); wr(1'b1, 8'h40);
        wr(1'b0, 8'h10);
        chk("R2 restart base cleared", vec_base, 0);
        wr(1'b1, 8'h8F);
        chk("R2 restart base", vec_base, 8'h88);
        wr(1'b1, 8'h00);
        chk("R2 restart done", setup_busy, 0);

        // R8 read selection
        req_vec = 8'h3C; svc_vec = 8'hC1;
        wr(1'b0, 8'h0B); rd(1'b0, v); chk("R8 svc", v, 8'hC1);
        wr(1'b0, 8'h0A); rd(1'b0, v); chk("R8 req", v, 8'h3C);
        wr(1'b0, 8'h09); rd(1'b0, v); chk("R8 sel kept", v, 8'h3C);
        wr(1'b0, 8'h0B); wr(1'b0, 8'h10);
        rd(1'b0, v); chk("R2 setup resets select", v, 8'h3C);
        wr(1'b1, 8'h00); wr(1'b1, 8'h00);

        // R9 special mask
        wr(1'b0, 8'h68); chk("R9 set", spec_mask, 1);
        wr(1'b0, 8'h28); chk("R9 hold", spec_mask, 1);
        wr(1'b0, 8'h48); chk("R9 clear", spec_mask, 0);

        // R10 / R11 rank command sweep
        wr(1'b1, 8'h96);
        exp_rot = 1'b0;
        for (int op = 0; op < 8; op++) begin
            for (int lv = 0; lv < 8; lv++) begin
                wr(1'b0, {op[2:0], 2'b00, lv[2:0]});
                exp_strobe = !(op == 0 || op == 2 || op == 4);
                if (op == 0) exp_rot = 1'b0;
                if (op == 4) exp_rot = 1'b1;
                chk("R11 strobe", cmd_valid, exp_strobe);
                if (exp_strobe) begin
                    chk("R11 op", cmd_op, op);
                    chk("R11 level", cmd_level, lv);
                end
                chk("R10 rotate flag", rot_auto_eoi, exp_rot);
                chk("R11 mask untouched", mask_o, 8'h96);
                @(negedge clk);
                chk("R11 strobe one cycle", cmd_valid, 0);
            end
        end

        // R12 poll
        wr(1'b0, 8'h0A);
        req_vec = 8'h81;
        pend_valid = 1'b1;
        for (int n = 0; n < 8; n++) begin
            pend_num = 3'(n);
            wr(1'b0, 8'h0C);
            rd(1'b0, v);
            chk("R12 poll value", v, n);
            chk("R12 poll ack", poll_ack, 1);
            chk("R12 poll num", poll_num, n);
            rd(1'b0, v);
            chk("R12 disarmed", v, 8'h81);
            chk("R12 ack one shot", poll_ack, 0);
        end
        pend_valid = 1'b0;
        pend_num = 3'd2;
        wr(1'b0, 8'h0C);
        rd(1'b1, v);
        chk("R12 idle code", v, 7);
        chk("R12 no ack when idle", poll_ack, 0);
        rd(1'b1, v);
        chk("R12 disarmed mask read", v, 8'h96);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule